// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block presents interrupts to one processor. It keeps a 32-bit pending word that holds the current processor priority and the number of the source being presented. It also keeps the priority of that pending source and a request priority for inter-processor interrupts. A source controller offers interrupts to it, each with a source number and a priority. The presenter either takes the offer, which may displace a less favoured pending source, or bounces the offer back. A lower priority value is more favoured, and 0xff means least favoured or nothing pending.

The processor side issues one operation per cycle through a small command port. The operations are accept, poll, set current priority, set inter-processor request priority and end-of-interrupt. The block answers the source layer with one-cycle pulses: reject (with a source number), end-of-interrupt (with a source number) and resend. It drives a level interrupt line that is high exactly while a source is pending. An inter-processor interrupt uses the fixed source number 2 and has no owner, so displacing it never produces a reject pulse.

Top module: `int_presenter`

## Requirements
- R1: After a synchronous reset the pending word is 0 (priority byte 0, source 0), the pending priority and the request priority are 0xff, the interrupt line is low and no pulse is active.
- R2: An offered interrupt whose priority is greater than or equal to the current priority is bounced: in the next cycle rej_valid pulses with rej_src equal to the offered source, and the state is unchanged.
- R3: An offered interrupt is also bounced when a source is pending whose pending priority is less than or equal to the offered priority.
- R4: An offered interrupt that is not bounced is latched with its priority and raises irq_o in the next cycle; if a source taken from the source layer was pending, that earlier source is rejected in the same cycle.
- R5: Accept (op_code 0) returns the old pending word (priority in bits 31:24, source in bits 23:0) on rd_data with rd_valid in the next cycle, lowers irq_o, moves the old pending priority into the current priority byte, clears the source field and sets the pending priority to 0xff.
- R6: Set current priority (op_code 2, value in op_data[7:0]) with a value below the current one clears a pending source when the new value is less than or equal to its pending priority: irq_o falls and a source-layer-owned source is rejected.
- R7: Set current priority with a value equal to or above the current one, while nothing is pending, pulses resend_valid; if the request priority is below the new value an inter-processor interrupt is presented at once.
- R8: Set request priority (op_code 3, value in op_data[7:0]) below the current priority presents an inter-processor interrupt (source 2, pending priority = the value) unless a source is pending with a pending priority less than or equal to the value; a displaced source-layer-owned source is rejected.
- R9: Displacing a pending inter-processor interrupt, by an offer or by a new request priority, produces no reject pulse.
- R10: End-of-interrupt (op_code 4) copies op_data[31:24] into the current priority and pulses eoi_valid with eoi_src = op_data[23:0]; if nothing is pending it also pulses resend_valid, after running the inter-processor check against the new priority.
- R11: Poll (op_code 1) returns the pending word on rd_data and the request priority on rd_mfrr in the next cycle without changing any state; op_code values 5 to 7 change nothing.
- R12: While op_valid is high, req_ready is low and an offered interrupt is neither taken nor rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Source layer offers an interrupt |
| req_ready | output | 1 | Offer is examined this cycle |
| req_src | input | 24 | Offered source number |
| req_prio | input | 8 | Offered priority |
| op_valid | input | 1 | Processor operation strobe |
| op_code | input | 3 | Operation: 0 accept, 1 poll, 2 set priority, 3 set request priority, 4 end-of-interrupt |
| op_data | input | 32 | Operation operand |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Pending word returned by accept or poll |
| rd_mfrr | output | 8 | Request priority returned with a read |
| irq_o | output | 1 | Level interrupt to the processor |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source layer |
| eoi_src | output | 24 | Source number being ended |
| resend_valid | output | 1 | Resend request pulse to the source layer |

## Verification
A corrupted pending source or pending priority shows up one cycle later on the ports: the interrupt line disagrees with a following poll, or the next offer is taken or bounced against the wrong reference. An ownership bit that is wrong shows as a missing or spurious reject pulse on the very next displacement, which is why the sequence mixes offered sources and inter-processor interrupts as displacers and as victims. A wrong current priority is exposed by the priority byte of the next accept or poll and by whether a following write produces resend.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int WORD_W = SRC_W + PRIO_W;

    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [SRC_W-1:0]  IPI_SRC   = SRC_W'(2);

    typedef enum logic [2:0] {
        OP_ACCEPT   = 3'd0,
        OP_POLL     = 3'd1,
        OP_SET_CPPR = 3'd2,
        OP_SET_MFRR = 3'd3,
        OP_EOI      = 3'd4
    } op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  src;
    } pend_word_t;

    typedef struct packed {
        pend_word_t        word;
        logic [PRIO_W-1:0] pend_prio;
        logic              owned;
    } pres_state_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } src_pulse_t;

    localparam pres_state_t STATE_RESET = '{
        word:      '{cppr: '0, src: '0},
        pend_prio: PRIO_NONE,
        owned:     1'b0
    };

    function automatic logic favours(input logic [PRIO_W-1:0] a,
                                     input logic [PRIO_W-1:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/ipc_req_judge.sv
module ipc_req_judge
    import ipc_pkg::*;
(
    input  logic [PRIO_W-1:0] cur_cppr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              owned,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              take,
    output logic              bump_owner
);

    logic beats_cppr;
    logic blocked_by_pending;

    always_comb begin
        beats_cppr         = favours(offer_prio, cur_cppr);
        blocked_by_pending = busy && !favours(offer_prio, pend_prio);
        take               = beats_cppr && !blocked_by_pending;
        bump_owner         = take && busy && owned;
    end

endmodule

// File: rtl/ipc_ipi_unit.sv
module ipc_ipi_unit
    import ipc_pkg::*;
(
    input  logic              enable,
    input  logic [PRIO_W-1:0] cand_mfrr,
    input  logic [PRIO_W-1:0] cand_cppr,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              owned,
    output logic              present,
    output logic              bump_owner
);

    logic run;
    logic held;

    always_comb begin
        run        = enable && favours(cand_mfrr, cand_cppr);
        held       = busy && !favours(cand_mfrr, pend_prio);
        present    = run && !held;
        bump_owner = present && busy && owned;
    end

endmodule

// File: rtl/int_presenter.sv
module int_presenter
    import ipc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [PRIO_W-1:0] rd_mfrr,
    output logic              irq_o,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_valid
);

    pres_state_t       st_q, st_d;
    logic [PRIO_W-1:0] mfrr_q, mfrr_d;
    logic              irq_q, irq_d;
    src_pulse_t        rej_q, rej_d;
    src_pulse_t        eoi_q, eoi_d;
    logic              resend_q, resend_d;
    logic              rdv_q, rdv_d;
    pend_word_t        rd_q, rd_d;
    logic [PRIO_W-1:0] rdm_q, rdm_d;

    logic              busy;
    logic              offer_take, offer_bump;
    logic              ipi_en;
    logic [PRIO_W-1:0] ipi_mfrr, ipi_cppr;
    logic              ipi_present, ipi_bump;
    logic [PRIO_W-1:0] op_low_val;
    logic [PRIO_W-1:0] op_high_val;

    assign busy        = (st_q.word.src != '0);
    assign op_low_val  = op_data[PRIO_W-1:0];
    assign op_high_val = op_data[WORD_W-1:SRC_W];
    assign req_ready   = !op_valid;

    ipc_req_judge u_judge (
        .cur_cppr   (st_q.word.cppr),
        .busy       (busy),
        .pend_prio  (st_q.pend_prio),
        .owned      (st_q.owned),
        .offer_prio (req_prio),
        .take       (offer_take),
        .bump_owner (offer_bump)
    );

    ipc_ipi_unit u_ipi (
        .enable     (ipi_en),
        .cand_mfrr  (ipi_mfrr),
        .cand_cppr  (ipi_cppr),
        .busy       (busy),
        .pend_prio  (st_q.pend_prio),
        .owned      (st_q.owned),
        .present    (ipi_present),
        .bump_owner (ipi_bump)
    );

    always_comb begin
        st_d     = st_q;
        mfrr_d   = mfrr_q;
        irq_d    = irq_q;
        rej_d    = '0;
        eoi_d    = '0;
        resend_d = 1'b0;
        rdv_d    = 1'b0;
        rd_d     = rd_q;
        rdm_d    = rdm_q;
        ipi_en   = 1'b0;
        ipi_mfrr = mfrr_q;
        ipi_cppr = st_q.word.cppr;

        if (op_valid) begin
            case (op_e'(op_code))
                OP_ACCEPT: begin
                    rdv_d          = 1'b1;
                    rd_d           = st_q.word;
                    rdm_d          = mfrr_q;
                    st_d.word.cppr = st_q.pend_prio;
                    st_d.word.src  = '0;
                    st_d.pend_prio = PRIO_NONE;
                    st_d.owned     = 1'b0;
                    irq_d          = 1'b0;
                end
                OP_POLL: begin
                    rdv_d = 1'b1;
                    rd_d  = st_q.word;
                    rdm_d = mfrr_q;
                end
                OP_SET_CPPR: begin
                    st_d.word.cppr = op_low_val;
                    if (favours(op_low_val, st_q.word.cppr)) begin
                        if (busy && !favours(st_q.pend_prio, op_low_val)) begin
                            st_d.word.src  = '0;
                            st_d.pend_prio = PRIO_NONE;
                            st_d.owned     = 1'b0;
                            irq_d          = 1'b0;
                            if (st_q.owned) begin
                                rej_d = '{valid: 1'b1, src: st_q.word.src};
                            end
                        end
                    end else if (!busy) begin
                        resend_d = 1'b1;
                        ipi_en   = 1'b1;
                        ipi_cppr = op_low_val;
                    end
                end
                OP_SET_MFRR: begin
                    mfrr_d   = op_low_val;
                    ipi_en   = 1'b1;
                    ipi_mfrr = op_low_val;
                end
                OP_EOI: begin
                    st_d.word.cppr = op_high_val;
                    eoi_d          = '{valid: 1'b1, src: op_data[SRC_W-1:0]};
                    if (!busy) begin
                        resend_d = 1'b1;
                        ipi_en   = 1'b1;
                        ipi_cppr = op_high_val;
                    end
                end
                default: begin
                end
            endcase
        end else if (req_valid) begin
            if (offer_take) begin
                if (offer_bump) begin
                    rej_d = '{valid: 1'b1, src: st_q.word.src};
                end
                st_d.word.src  = req_src;
                st_d.pend_prio = req_prio;
                st_d.owned     = 1'b1;
                irq_d          = 1'b1;
            end else begin
                rej_d = '{valid: 1'b1, src: req_src};
            end
        end

        if (ipi_present) begin
            if (ipi_bump) begin
                rej_d = '{valid: 1'b1, src: st_q.word.src};
            end
            st_d.word.src  = IPI_SRC;
            st_d.pend_prio = ipi_mfrr;
            st_d.owned     = 1'b0;
            irq_d          = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= STATE_RESET;
            mfrr_q   <= PRIO_NONE;
            irq_q    <= 1'b0;
            rej_q    <= '0;
            eoi_q    <= '0;
            resend_q <= 1'b0;
            rdv_q    <= 1'b0;
            rd_q     <= '0;
            rdm_q    <= '0;
        end else begin
            st_q     <= st_d;
            mfrr_q   <= mfrr_d;
            irq_q    <= irq_d;
            rej_q    <= rej_d;
            eoi_q    <= eoi_d;
            resend_q <= resend_d;
            rdv_q    <= rdv_d;
            rd_q     <= rd_d;
            rdm_q    <= rdm_d;
        end
    end

    assign irq_o        = irq_q;
    assign rej_valid    = rej_q.valid;
    assign rej_src      = rej_q.src;
    assign eoi_valid    = eoi_q.valid;
    assign eoi_src      = eoi_q.src;
    assign resend_valid = resend_q;
    assign rd_valid     = rdv_q;
    assign rd_data      = rd_q;
    assign rd_mfrr      = rdm_q;

    // R1: the line follows the pending source field, kept in a separate register
    a_r1_line_tracks_pending: assert property (@(posedge clk) disable iff (rst)
        irq_o == (st_q.word.src != '0));

    // R2: an offer not better than the current priority bounces unchanged
    a_r2_offer_bounced: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !op_valid && !favours(req_prio, st_q.word.cppr))
        |=> (rej_valid && rej_src == $past(req_src) && $stable(st_q)));

    // R5: accept leaves nothing pending
    a_r5_accept_empties: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ACCEPT)
        |=> (rd_valid && !irq_o && st_q.word.src == '0 && st_q.pend_prio == PRIO_NONE));

    // R9: a pending inter-processor interrupt displaced by a request priority is not rejected
    a_r9_ipi_silent: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SET_MFRR && busy && !st_q.owned)
        |=> !rej_valid);

    // R10: end-of-interrupt forwards the low field of the written word
    a_r10_eoi_forward: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_EOI)
        |=> (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0])));

    // R11: poll touches no state
    a_r11_poll_inert: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_POLL)
        |=> ($stable(st_q) && $stable(mfrr_q) && $stable(irq_o)));

    // R12: an offer that coincides with an operation is not rejected by the offer path
    a_r12_offer_stalled: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_valid && op_code == OP_POLL) |=> !rej_valid);

endmodule

// File: tb/int_presenter_test.sv
`timescale 1ns/100ps
module int_presenter_test;
    import ipc_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [SRC_W-1:0]  req_src;
    logic [PRIO_W-1:0] req_prio;
    logic              op_valid;
    logic [2:0]        op_code;
    logic [WORD_W-1:0] op_data;
    logic              rd_valid;
    logic [WORD_W-1:0] rd_data;
    logic [PRIO_W-1:0] rd_mfrr;
    logic              irq_o;
    logic              rej_valid;
    logic [SRC_W-1:0]  rej_src;
    logic              eoi_valid;
    logic [SRC_W-1:0]  eoi_src;
    logic              resend_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    int_presenter uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_prio(req_prio),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_mfrr(rd_mfrr),
        .irq_o(irq_o), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        is_op;
        logic [2:0]  code;
        logic [31:0] data;
        logic        e_irq;
        logic        e_rej;
        logic [23:0] e_rsrc;
        logic        e_eoi;
        logic [23:0] e_esrc;
        logic        e_res;
        logic        e_rdv;
        logic [31:0] e_rd;
        logic [7:0]  e_mfrr;
    } vec_t;

    localparam int NV = 26;
    // offers carry {priority, source} in data; ops carry their operand
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b0, 3'd0, 32'h05000010, 1'b0, 1'b1, 24'h10, 1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R2 cppr 0
        '{4'd10, 1'b1, 3'd4, 32'hff000000, 1'b0, 1'b0, 24'h0,  1'b1, 24'h0,  1'b1, 1'b0, 32'h0,        8'h0},  // R10
        '{4'd4,  1'b0, 3'd0, 32'h05000010, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R4
        '{4'd3,  1'b0, 3'd0, 32'h05000020, 1'b1, 1'b1, 24'h20, 1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R3 equal prio
        '{4'd4,  1'b0, 3'd0, 32'h03000030, 1'b1, 1'b1, 24'h10, 1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R4 displace
        '{4'd11, 1'b1, 3'd1, 32'h0,        1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'hff000030, 8'hff}, // R11
        '{4'd6,  1'b1, 3'd2, 32'h00000004, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R6 keep
        '{4'd6,  1'b1, 3'd2, 32'h00000003, 1'b0, 1'b1, 24'h30, 1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R6 clear
        '{4'd11, 1'b1, 3'd1, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'h03000000, 8'hff}, // R11
        '{4'd8,  1'b1, 3'd3, 32'h00000001, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R8
        '{4'd9,  1'b0, 3'd0, 32'h00000040, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R9 offer over IPI
        '{4'd5,  1'b1, 3'd0, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'h03000040, 8'h01}, // R5
        '{4'd11, 1'b1, 3'd1, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'h00000000, 8'h01}, // R11
        '{4'd10, 1'b1, 3'd4, 32'h05000040, 1'b1, 1'b0, 24'h0,  1'b1, 24'h40, 1'b1, 1'b0, 32'h0,        8'h0},  // R10 resend+IPI
        '{4'd11, 1'b1, 3'd1, 32'h0,        1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'h05000002, 8'h01}, // R11
        '{4'd9,  1'b1, 3'd3, 32'h00000000, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R9 IPI over IPI
        '{4'd3,  1'b0, 3'd0, 32'h00000050, 1'b1, 1'b1, 24'h50, 1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R3
        '{4'd8,  1'b1, 3'd3, 32'h00000004, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R8 held
        '{4'd5,  1'b1, 3'd0, 32'h0,        1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'h05000002, 8'h04}, // R5
        '{4'd7,  1'b1, 3'd2, 32'h00000006, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1, 1'b0, 32'h0,        8'h0},  // R7
        '{4'd11, 1'b1, 3'd1, 32'h0,        1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'h06000002, 8'h04}, // R11
        '{4'd4,  1'b0, 3'd0, 32'h02000060, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R4
        '{4'd8,  1'b1, 3'd3, 32'h00000003, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R8 held
        '{4'd8,  1'b1, 3'd3, 32'h00000001, 1'b1, 1'b1, 24'h60, 1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R8 bump owner
        '{4'd11, 1'b1, 3'd7, 32'h00000000, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b0, 32'h0,        8'h0},  // R11 undefined code
        '{4'd11, 1'b1, 3'd1, 32'h0,        1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 1'b1, 32'h06000002, 8'h01}  // R11
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_src = '0; req_prio = '0;
        op_valid = 1'b0; op_code = '0; op_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_poll(output logic [31:0] w, output logic [7:0] m);
        op_valid = 1'b1; op_code = 3'd1;
        @(negedge clk);
        idle_inputs();
        w = rd_data; m = rd_mfrr;
    endtask

    initial begin
        logic [31:0] w;
        logic [7:0]  m;
        rst = 1'b1;
        idle_inputs();
        do_reset();

        // R1 reset state
        check(!irq_o && !rej_valid && !eoi_valid && !resend_valid && !rd_valid,
              "R1 outputs after reset", {27'd0, irq_o, rej_valid, eoi_valid, resend_valid, rd_valid}, 32'd0);
        do_poll(w, m);
        check(w == 32'h0, "R1 pending word after reset", w, 32'h0);
        check(m == 8'hff, "R1 request priority after reset", {24'd0, m}, 32'hff);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].is_op) begin
                op_valid = 1'b1; op_code = TBL[i].code; op_data = TBL[i].data;
            end else begin
                req_valid = 1'b1; req_prio = TBL[i].data[31:24]; req_src = TBL[i].data[23:0];
            end
            @(negedge clk);
            idle_inputs();
            check(irq_o == TBL[i].e_irq, $sformatf("R%0d irq step %0d", TBL[i].rq, i), {31'd0, irq_o}, {31'd0, TBL[i].e_irq});
            check(rej_valid == TBL[i].e_rej, $sformatf("R%0d reject step %0d", TBL[i].rq, i), {31'd0, rej_valid}, {31'd0, TBL[i].e_rej});
            if (TBL[i].e_rej)
                check(rej_src == TBL[i].e_rsrc, $sformatf("R%0d reject source step %0d", TBL[i].rq, i), {8'd0, rej_src}, {8'd0, TBL[i].e_rsrc});
            check(eoi_valid == TBL[i].e_eoi, $sformatf("R%0d eoi step %0d", TBL[i].rq, i), {31'd0, eoi_valid}, {31'd0, TBL[i].e_eoi});
            if (TBL[i].e_eoi)
                check(eoi_src == TBL[i].e_esrc, $sformatf("R%0d eoi source step %0d", TBL[i].rq, i), {8'd0, eoi_src}, {8'd0, TBL[i].e_esrc});
            check(resend_valid == TBL[i].e_res, $sformatf("R%0d resend step %0d", TBL[i].rq, i), {31'd0, resend_valid}, {31'd0, TBL[i].e_res});
            check(rd_valid == TBL[i].e_rdv, $sformatf("R%0d read valid step %0d", TBL[i].rq, i), {31'd0, rd_valid}, {31'd0, TBL[i].e_rdv});
            if (TBL[i].e_rdv) begin
                check(rd_data == TBL[i].e_rd, $sformatf("R%0d read word step %0d", TBL[i].rq, i), rd_data, TBL[i].e_rd);
                check(rd_mfrr == TBL[i].e_mfrr, $sformatf("R%0d read request prio step %0d", TBL[i].rq, i), {24'd0, rd_mfrr}, {24'd0, TBL[i].e_mfrr});
            end
        end

        // R12: offer during an operation is stalled (state: cppr 6, IPI pending at prio 1)
        req_valid = 1'b1; req_src = 24'h70; req_prio = 8'h00;
        op_valid = 1'b1; op_code = 3'd1;
        #1;
        check(!req_ready, "R12 ready low during op", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        idle_inputs();
        check(!rej_valid, "R12 no reject for stalled offer", {31'd0, rej_valid}, 32'd0);
        check(rd_data == 32'h06000002, "R12 stalled offer not taken", rd_data, 32'h06000002);
        do_poll(w, m);
        check(w == 32'h06000002, "R12 state after stall", w, 32'h06000002);

        // R1 reset mid-run, then R2 boundary: priority 0 against cppr 0
        do_reset();
        check(!irq_o, "R1 irq low after mid-run reset", {31'd0, irq_o}, 32'd0);
        do_poll(w, m);
        check(w == 32'h0 && m == 8'hff, "R1 state after mid-run reset", {w[31:8], m}, 32'h000000ff);
        req_valid = 1'b1; req_src = 24'h80; req_prio = 8'h00;
        @(negedge clk);
        idle_inputs();
        check(rej_valid && rej_src == 24'h80, "R2 equal priority bounced", {8'd0, rej_src}, 32'h80);
        check(!irq_o, "R2 line stays low", {31'd0, irq_o}, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule